// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block is the interface-controller half of a transmit descriptor queue that lives in memory. Software places descriptors in the queue. Each descriptor names a buffer start address and a byte count. A transmit-demand strobe wakes the engine. The engine then takes descriptors in arrival order, reads each buffer one byte at a time over a request/response read port, and sends the bytes out on a byte-stream transmit port. Packets go out back-to-back, kept apart only by a programmable minimum idle gap.

When a packet ends, the engine writes a completion word into that descriptor's status slot. The word carries a done flag, an underrun flag and the byte count actually sent. The engine then looks at the queue again straight away. If more work is waiting, it continues with no processor involvement. If the queue is empty, it parks until the next demand. Software reads status words through an index-addressed read port.

Top module: `tx_desc_queue_engine`

## Requirements
- R1: After reset, qCount is 0, txValid and txLast are 0, and rdReq is 0.
- R2: A push is accepted only while qCount is below DEPTH (512). An accepted push raises qCount by one. A push while the queue is full changes neither qCount nor the transmitted stream, and qFull reads 1 exactly when qCount equals DEPTH.
- R3: A transmit demand with an empty queue, or a push with no demand while the engine is idle, starts no buffer read and no transmission.
- R4: Once a demand arrives with work queued, the engine reads addresses bufAddr, bufAddr+1, … bufAddr+len-1. It sends each returned byte on txData with txValid high for one cycle, and txLast is high only on the final byte. rdReq stays high until rdAck answers it.
- R5: Descriptors are served strictly in push order.
- R6: Between the txLast byte of one packet and the first byte of the next, txValid is low for at least gapCycles cycles. A burst from one demand has no more than gapCycles+8 such cycles.
- R7: A completed packet's status word is bit 12 = done (1), bit 11 = underrun (0), and bits 10:0 = length. A freshly pushed slot reads all zero.
- R8: A response with rdErr high aborts the packet. No further bytes are sent and no txLast is given. The status reads done=1, underrun=1 and length = the bytes sent before the error. The next descriptor is still served.
- R9: After each write-back the engine serves any queued descriptor without a new demand, including one pushed during or in the same cycle as that write-back. Once the queue is empty it goes idle.
- R10: A zero-length descriptor sends no bytes and completes with status done=1, underrun=0, length 0.
- R11: qCount falls by one at each status write-back, and qCount equals accepted pushes minus completed descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Enqueue a descriptor this cycle |
| pushAddr | input | 16 | Buffer start address of the descriptor |
| pushLen | input | 11 | Byte count of the descriptor |
| qCount | output | 10 | Descriptors queued or in service |
| qFull | output | 1 | Queue holds DEPTH entries |
| txDemand | input | 1 | Transmit-demand strobe |
| gapCycles | input | 8 | Minimum idle cycles between packets |
| rdReq | output | 1 | Buffer read request, held until answered |
| rdAddr | output | 16 | Buffer byte address |
| rdAck | input | 1 | Read response valid |
| rdErr | input | 1 | Read response carries no data (underrun) |
| rdData | input | 8 | Read response byte |
| txValid | output | 1 | Transmit byte valid |
| txData | output | 8 | Transmit byte |
| txLast | output | 1 | Final byte of the packet |
| stRdIdx | input | 9 | Status slot to read |
| stRdData | output | 13 | Status word of that slot |

## Verification
Two events can meet in one cycle: software pushing a new descriptor, and the engine writing back status and advancing the head. The bench provokes this by watching for the txLast byte and driving a push into the very edge where the write-back happens. It then judges the result three ways. The queue count must net to zero. The pushed descriptor must be sent with no second demand. Both status slots must read back the expected done and length words. A second overlap, a demand arriving while the queue is empty, must be shown to start no read at all.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_READ, ST_WRBACK, ST_GAP
  } engState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadDesc;
    logic sendByte;
    logic markErr;
    logic writeStatus;
    logic loadGap;
    logic gapTick;
  } ctrlStrb_t;
endpackage

// File: rtl/tdq_datapath.sv
module tdq_datapath
  import tdq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int ADDRW = 16,
  parameter int LENW  = 11,
  parameter int GAPW  = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1,
  localparam int STW  = LENW + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic             pushValid,
  input  logic [ADDRW-1:0] pushAddr,
  input  logic [LENW-1:0]  pushLen,
  input  logic [GAPW-1:0]  gapCycles,
  input  logic [7:0]       rdData,
  input  logic [IDXW-1:0]  stRdIdx,
  output logic [PTRW-1:0]  qCount,
  output logic             qFull,
  output logic             qEmpty,
  output logic             headLenZero,
  output logic             lastByte,
  output logic             gapDone,
  output logic [ADDRW-1:0] rdAddr,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txLast,
  output logic [STW-1:0]   stRdData
);
  logic [ADDRW-1:0] descAddrMem [DEPTH];
  logic [LENW-1:0]  descLenMem  [DEPTH];
  logic [STW-1:0]   statMem     [DEPTH];

  logic [PTRW-1:0]  headPtr, tailPtr;
  logic [ADDRW-1:0] curAddr;
  logic [LENW-1:0]  curLen, byteCnt;
  logic             errFlag;
  logic [GAPW-1:0]  gapCnt;

  wire [IDXW-1:0] headIdx = headPtr[IDXW-1:0];
  wire [IDXW-1:0] tailIdx = tailPtr[IDXW-1:0];
  wire            pushOk  = pushValid && !qFull;

  assign qCount      = tailPtr - headPtr;
  assign qEmpty      = (headPtr == tailPtr);
  assign qFull       = (qCount == PTRW'(DEPTH));
  assign headLenZero = (descLenMem[headIdx] == '0);
  assign lastByte    = ((byteCnt + LENW'(1)) == curLen);
  assign gapDone     = (gapCnt == '0);
  assign rdAddr      = curAddr + ADDRW'(byteCnt);
  assign stRdData    = statMem[stRdIdx];

  // Descriptor and status storage (two write ports, never the same slot)
  always_ff @(posedge clk) begin
    if (pushOk) begin
      descAddrMem[tailIdx] <= pushAddr;
      descLenMem[tailIdx]  <= pushLen;
      statMem[tailIdx]     <= '0;
    end
    if (strb.writeStatus)
      statMem[headIdx] <= {1'b1, errFlag, byteCnt};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      curAddr <= '0;
      curLen  <= '0;
      byteCnt <= '0;
      errFlag <= 1'b0;
      gapCnt  <= '0;
      txValid <= 1'b0;
      txData  <= '0;
      txLast  <= 1'b0;
    end else begin
      if (pushOk) tailPtr <= tailPtr + PTRW'(1);
      if (strb.writeStatus) headPtr <= headPtr + PTRW'(1);
      if (strb.loadDesc) begin
        curAddr <= descAddrMem[headIdx];
        curLen  <= descLenMem[headIdx];
        byteCnt <= '0;
        errFlag <= 1'b0;
      end
      if (strb.markErr) errFlag <= 1'b1;
      if (strb.sendByte) begin
        txValid <= 1'b1;
        txData  <= rdData;
        txLast  <= lastByte;
        byteCnt <= byteCnt + LENW'(1);
      end else begin
        txValid <= 1'b0;
        txLast  <= 1'b0;
      end
      if (strb.loadGap)      gapCnt <= gapCycles;
      else if (strb.gapTick) gapCnt <= gapCnt - GAPW'(1);
    end
  end

  // Idle-run tracker used by the gap check
  logic [GAPW:0]   sinceLast;
  logic [GAPW-1:0] gapHeld;
  logic            seenLast;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceLast <= '0;
      seenLast  <= 1'b0;
      gapHeld   <= '0;
    end else begin
      if (strb.loadGap) gapHeld <= gapCycles;
      if (txValid && txLast) begin
        sinceLast <= '0;
        seenLast  <= 1'b1;
      end else if (!txValid && sinceLast != '1) begin
        sinceLast <= sinceLast + 1'b1;
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= PTRW'(DEPTH));
  assert_gap_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && seenLast) |-> (sinceLast >= {1'b0, gapHeld}));
  assert_wb_nonempty_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeStatus |-> !qEmpty);
  assert_last_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txLast) |-> (byteCnt == curLen));
endmodule

// File: rtl/tdq_ctrl.sv
module tdq_ctrl
  import tdq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txDemand,
  input  logic      qEmpty,
  input  logic      headLenZero,
  input  logic      lastByte,
  input  logic      gapDone,
  input  logic      rdAck,
  input  logic      rdErr,
  output logic      rdReq,
  output ctrlStrb_t strb
);
  engState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    rdReq     = 1'b0;
    unique case (state)
      ST_IDLE:
        if (txDemand && !qEmpty) stateNext = ST_FETCH;
      ST_FETCH: begin
        strb.loadDesc = 1'b1;
        stateNext     = headLenZero ? ST_WRBACK : ST_READ;
      end
      ST_READ: begin
        rdReq = 1'b1;
        if (rdAck) begin
          if (rdErr) begin
            strb.markErr = 1'b1;
            stateNext    = ST_WRBACK;
          end else begin
            strb.sendByte = 1'b1;
            if (lastByte) stateNext = ST_WRBACK;
          end
        end
      end
      ST_WRBACK: begin
        strb.writeStatus = 1'b1;
        strb.loadGap     = 1'b1;
        stateNext        = ST_GAP;
      end
      ST_GAP:
        if (gapDone) stateNext = qEmpty ? ST_IDLE : ST_FETCH;
        else         strb.gapTick = 1'b1;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !txDemand) |=> !rdReq);
endmodule

// File: rtl/tx_desc_queue_engine.sv
module tx_desc_queue_engine
  import tdq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int ADDRW = 16,
  parameter int LENW  = 11,
  parameter int GAPW  = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1,
  localparam int STW  = LENW + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [ADDRW-1:0] pushAddr,
  input  logic [LENW-1:0]  pushLen,
  output logic [PTRW-1:0]  qCount,
  output logic             qFull,
  input  logic             txDemand,
  input  logic [GAPW-1:0]  gapCycles,
  output logic             rdReq,
  output logic [ADDRW-1:0] rdAddr,
  input  logic             rdAck,
  input  logic             rdErr,
  input  logic [7:0]       rdData,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txLast,
  input  logic [IDXW-1:0]  stRdIdx,
  output logic [STW-1:0]   stRdData
);
  ctrlStrb_t strb;
  logic qEmpty, headLenZero, lastByte, gapDone;

  tdq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .txDemand(txDemand), .qEmpty(qEmpty),
    .headLenZero(headLenZero), .lastByte(lastByte), .gapDone(gapDone),
    .rdAck(rdAck), .rdErr(rdErr), .rdReq(rdReq), .strb(strb)
  );

  tdq_datapath #(.DEPTH(DEPTH), .ADDRW(ADDRW), .LENW(LENW), .GAPW(GAPW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .pushValid(pushValid),
    .pushAddr(pushAddr), .pushLen(pushLen), .gapCycles(gapCycles),
    .rdData(rdData), .stRdIdx(stRdIdx), .qCount(qCount), .qFull(qFull),
    .qEmpty(qEmpty), .headLenZero(headLenZero), .lastByte(lastByte),
    .gapDone(gapDone), .rdAddr(rdAddr), .txValid(txValid), .txData(txData),
    .txLast(txLast), .stRdData(stRdData)
  );
endmodule

// File: tb/tx_desc_queue_engine_tb_top.sv
module tx_desc_queue_engine_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [15:0] pushAddr = '0;
  logic [10:0] pushLen = '0;
  logic [9:0] qCount;
  logic qFull;
  logic txDemand = 1'b0;
  logic [7:0] gapCycles = 8'd0;
  logic rdReq;
  logic [15:0] rdAddr;
  logic rdAck = 1'b0;
  logic rdErr = 1'b0;
  logic [7:0] rdData = '0;
  logic txValid, txLast;
  logic [7:0] txData;
  logic [8:0] stRdIdx = '0;
  logic [12:0] stRdData;

  always #5 clk = ~clk;

  tx_desc_queue_engine dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushAddr(pushAddr),
    .pushLen(pushLen), .qCount(qCount), .qFull(qFull), .txDemand(txDemand),
    .gapCycles(gapCycles), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck),
    .rdErr(rdErr), .rdData(rdData), .txValid(txValid), .txData(txData),
    .txLast(txLast), .stRdIdx(stRdIdx), .stRdData(stRdData)
  );

  int nChecks = 0, nFail = 0, cyc = 0, reqCnt = 0, logN = 0;
  int slotNext = 0;
  bit errEn = 1'b0;
  logic [15:0] errAddr = '0;
  logic [7:0] logData [2048];
  bit         logLast [2048];
  int         logCyc  [2048];

  function automatic logic [7:0] memByte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // Buffer memory model: answers one cycle after a request is seen
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rdReq && !rdAck) begin
      rdAck  <= 1'b1;
      rdData <= memByte(rdAddr);
      rdErr  <= errEn && (rdAddr == errAddr);
    end else begin
      rdAck <= 1'b0;
      rdErr <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rdReq) reqCnt++;
    if (txValid && logN < 2048) begin
      logData[logN] = txData;
      logLast[logN] = txLast;
      logCyc[logN]  = cyc;
      logN++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushD(logic [15:0] a, logic [10:0] l);
    @(negedge clk);
    pushValid = 1'b1; pushAddr = a; pushLen = l;
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic demand();
    @(negedge clk); txDemand = 1'b1;
    @(negedge clk); txDemand = 1'b0;
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 20000 && qCount != 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic readStat(int idx, output logic [12:0] w);
    @(negedge clk); stRdIdx = 9'(idx); #1; w = stRdData;
  endtask

  task automatic chkPkt(int at, logic [15:0] a, int len, string req);
    for (int i = 0; i < len; i++) begin
      chk(logData[at+i] == memByte(a + 16'(i)), req, logData[at+i], memByte(a + 16'(i)));
      chk(logLast[at+i] == (i == len-1), req, logLast[at+i], i == len-1);
    end
  endtask

  task automatic chkStat(int slot, bit err, int len, string req);
    logic [12:0] w;
    readStat(slot % 512, w);
    chk(w == {1'b1, err, 11'(len)}, req, w, {1'b1, err, 11'(len)});
  endtask

  task automatic t_reset();
    chk(qCount == 0, "R1 qCount", qCount, 0);
    chk(!txValid && !txLast, "R1 tx", {txValid, txLast}, 0);
    chk(!rdReq, "R1 rdReq", rdReq, 0);
  endtask

  task automatic t_empty();
    logic [12:0] w;
    int r0 = reqCnt;
    demand();                    // R3: demand on empty queue
    repeat (20) @(negedge clk);
    chk(reqCnt == r0 && logN == 0, "R3 empty demand", reqCnt - r0, 0);
    pushD(16'h0100, 11'd5); slotNext++;
    repeat (20) @(negedge clk);
    chk(reqCnt == r0 && logN == 0, "R3 push no demand", logN, 0);
    chk(qCount == 1, "R2 count after push", qCount, 1);
    readStat(0, w);
    chk(w == 13'd0, "R7 fresh slot zero", w, 0);
  endtask

  task automatic t_single();
    int at = logN;
    gapCycles = 8'd3;
    demand();
    waitDrain();
    chk(logN - at == 5, "R4 byte count", logN - at, 5);
    chkPkt(at, 16'h0100, 5, "R4 bytes");
    chkStat(0, 1'b0, 5, "R7 status");
    chk(qCount == 0, "R11 count drained", qCount, 0);
  endtask

  task automatic t_burst();
    int at = logN, g;
    gapCycles = 8'd10;
    pushD(16'h0200, 11'd3); pushD(16'h0300, 11'd2); pushD(16'h0410, 11'd4);
    chk(qCount == 3, "R2 three queued", qCount, 3);
    demand();
    waitDrain();
    chk(logN - at == 9, "R5 burst bytes", logN - at, 9);
    chkPkt(at, 16'h0200, 3, "R5 first");
    chkPkt(at + 3, 16'h0300, 2, "R5 second");
    chkPkt(at + 5, 16'h0410, 4, "R5 third");
    g = logCyc[at+3] - logCyc[at+2] - 1;
    chk(g >= 10 && g <= 18, "R6 gap 1-2", g, 10);
    g = logCyc[at+5] - logCyc[at+4] - 1;
    chk(g >= 10 && g <= 18, "R6 gap 2-3", g, 10);
    chkStat(slotNext, 1'b0, 3, "R7 s1");
    chkStat(slotNext + 1, 1'b0, 2, "R7 s2");
    chkStat(slotNext + 2, 1'b0, 4, "R7 s3");
    slotNext += 3;
  endtask

  task automatic t_wbPush();   // push lands on the write-back edge
    int at = logN;
    gapCycles = 8'd4;
    pushD(16'h0500, 11'd6);
    demand();
    for (int i = 0; i < 200 && !(txValid && txLast); i++) @(negedge clk);
    pushValid = 1'b1; pushAddr = 16'h0600; pushLen = 11'd3;
    @(negedge clk);
    pushValid = 1'b0;
    waitDrain();
    chk(logN - at == 9, "R9 repoll bytes", logN - at, 9);
    chkPkt(at + 6, 16'h0600, 3, "R9 repoll data");
    chkStat(slotNext, 1'b0, 6, "R9 status a");
    chkStat(slotNext + 1, 1'b0, 3, "R9 status b");
    chk(qCount == 0, "R11 net zero", qCount, 0);
    slotNext += 2;
  endtask

  task automatic t_idleAfter();
    int at = logN;
    pushD(16'h0700, 11'd2);
    repeat (30) @(negedge clk);
    chk(logN == at, "R9 idle after drain", logN - at, 0);
    demand();
    waitDrain();
    chkPkt(at, 16'h0700, 2, "R9 resumed");
    slotNext++;
  endtask

  task automatic t_underrun();
    int at = logN;
    errEn = 1'b1; errAddr = 16'h0802;
    pushD(16'h0800, 11'd5); pushD(16'h0900, 11'd2);
    demand();
    waitDrain();
    errEn = 1'b0;
    chk(logN - at == 4, "R8 bytes", logN - at, 4);
    chk(!logLast[at+1], "R8 no last", logLast[at+1], 0);
    chkPkt(at + 2, 16'h0900, 2, "R8 next served");
    chkStat(slotNext, 1'b1, 2, "R8 status");
    chkStat(slotNext + 1, 1'b0, 2, "R8 next status");
    slotNext += 2;
  endtask

  task automatic t_zero();
    int at = logN;
    pushD(16'h0A00, 11'd0); pushD(16'h0B00, 11'd1);
    demand();
    waitDrain();
    chk(logN - at == 1, "R10 bytes", logN - at, 1);
    chkPkt(at, 16'h0B00, 1, "R10 next");
    chkStat(slotNext, 1'b0, 0, "R10 status");
    slotNext += 2;
  endtask

  task automatic t_full();
    int at = logN, bad = 0;
    gapCycles = 8'd0;
    for (int i = 0; i < 512; i++) pushD(16'h1000 + 16'(i), 11'd1);
    chk(qCount == 512, "R2 full count", qCount, 512);
    chk(qFull, "R2 qFull", qFull, 1);
    pushD(16'hFFFF, 11'd1);
    chk(qCount == 512, "R2 push ignored", qCount, 512);
    demand();
    waitDrain();
    chk(logN - at == 512, "R2 only 512 sent", logN - at, 512);
    for (int i = 0; i < 512; i++)
      if (logData[at+i] != memByte(16'h1000 + 16'(i))) bad++;
    chk(bad == 0, "R5 full order", bad, 0);
    chkStat(slotNext + 511, 1'b0, 1, "R7 last slot");
    chk(qCount == 0 && !qFull, "R11 full drained", qCount, 0);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_single();
    t_burst();
    t_wbPush();
    t_idleAfter();
    t_underrun();
    t_zero();
    t_full();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule